// File: doc/BRIEF.md
# Read/Write Serial Slave Port

This block is the slave side of a four-wire serial port for a converter that is configured through a control byte and read back as a 10-bit result. The port has an active-low chip select, a direction line that is high for reads and low for writes, a serial clock, a data input, and a data output with an output enable. All pin inputs are brought into the system clock domain through two flip-flops and are then edge-detected, so the host may toggle the pins at any speed well below the system clock.

A write captures eight bits, MSB first. The upper five bits of the byte pick the target register. If any of them is set, the whole byte goes to the 8-bit alarm threshold. If none is set, the low three bits go to the channel address. A rising edge on the direction line starts a read. It puts the MSB of the stored result on the output, and later falling serial-clock edges shift out the remaining bits. A read consumes the result. Until the conversion engine loads a new one, the port reports the data as invalid and shifts out zeros. A one-cycle strobe marks each read start so that the alarm logic can clear its indicator.

Top module: `rw_serial_port`

## Requirements
- R1: After reset the channel address is 000, the threshold is 153 (decimal), the output enable is low and the data-invalid flag is high.
- R2: While chip select is low and the direction line has fallen, the first 8 rising serial-clock edges capture the data input MSB first. Further rising edges in the same transfer have no effect.
- R3: When bits 7..3 of a captured byte are not all zero, the whole byte is written to the threshold and the channel address is kept. Otherwise bits 2..0 are written to the channel address and the threshold is kept.
- R4: Each write needs its own falling edge on the direction line. Serial-clock edges after a completed byte do not start a second byte.
- R5: A rising edge on the direction line while chip select is low enables the output and presents result bit 9.
- R6: During a read, the first falling serial-clock edge does not shift. Each later falling edge presents the next lower result bit. The host may stop after 8 bits or after all 10.
- R7: The output enable drops when chip select goes high or when the direction line falls, whichever comes first.
- R8: A read erases the result and raises the data-invalid flag. A read made without a new load shifts out zeros. A load of a new result clears the flag.
- R9: The read-end strobe is high for exactly one clock cycle for each qualifying rising edge of the direction line.
- R10: While chip select is high, edges on the serial clock and the direction line change no register, enable no output and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| rw | input | 1 | Direction pin: high for read, low for write |
| sclk | input | 1 | Serial clock pin, idles high |
| sdi | input | 1 | Serial data input pin |
| sdo | output | 1 | Serial data output value |
| sdo_en | output | 1 | Output enable for the serial data pad |
| result_in | input | 10 | Conversion result from the engine |
| result_load | input | 1 | One-cycle pulse that stores result_in |
| chan_addr | output | 3 | Selected channel (000 is the temperature sensor) |
| threshold | output | 8 | Alarm threshold byte |
| data_invalid | output | 1 | High when no unread result is held |
| read_end | output | 1 | One-cycle strobe at each read start |

## Verification
The assertions check on every clock cycle that the output turns off while chip select is high, that the read strobe never lasts two cycles and always comes with the output enabled, that a read leaves the data invalid, that a load makes it valid, and that the configuration registers do not change while the direction line is high. Only the bench scenarios show the bit order and the skipped first falling edge, the routing of bytes between the two registers, the discarding of surplus clocks, the zeros returned by a repeated read, and that pin activity is ignored while the chip is deselected.

// File: rtl/rw_serial_port.sv
module rw_serial_port #(
  parameter int RES_W    = 10,
  parameter int CTL_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int THR_INIT = 153
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  input  logic [RES_W-1:0]  result_in,
  input  logic              result_load,
  output logic [ADDR_W-1:0] chan_addr,
  output logic [CTL_W-1:0]  threshold,
  output logic              data_invalid,
  output logic              read_end
);
  localparam int CNT_W = $clog2(CTL_W);
  localparam logic [3:0] PIN_IDLE = 4'b1110;

  // pin order: {cs_n, rw, sclk, sdi}
  logic [3:0] s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= PIN_IDLE; s2 <= PIN_IDLE; s3 <= PIN_IDLE;
    end else begin
      s1 <= {cs_n, rw, sclk, sdi}; s2 <= s1; s3 <= s2;
    end

  wire cs_lo    = !s2[3];
  wire rw_hi    = s2[2];
  wire rw_rise  = s2[2] & !s3[2];
  wire rw_fall  = !s2[2] & s3[2];
  wire sck_rise = s2[1] & !s3[1];
  wire sck_fall = !s2[1] & s3[1];
  wire din      = s2[0];

  logic             wr_armed, rd_on, skip, res_ok;
  logic [CNT_W-1:0] wr_cnt;
  logic [CTL_W-1:0] wr_sh;
  logic [RES_W-1:0] rd_sh, res;

  wire [CTL_W-1:0] nxt_byte = {wr_sh[CTL_W-2:0], din};
  wire             to_thr   = |nxt_byte[CTL_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_armed <= 1'b0; rd_on <= 1'b0; skip <= 1'b0; res_ok <= 1'b0;
      wr_cnt <= '0; wr_sh <= '0; rd_sh <= '0; res <= '0;
      chan_addr <= '0; threshold <= CTL_W'(THR_INIT); read_end <= 1'b0;
    end else begin
      read_end <= 1'b0;
      if (!cs_lo) begin
        wr_armed <= 1'b0;
        rd_on    <= 1'b0;
      end else if (rw_fall) begin
        wr_armed <= 1'b1;
        wr_cnt   <= '0;
        rd_on    <= 1'b0;
      end else if (rw_rise) begin
        wr_armed <= 1'b0;
        rd_on    <= 1'b1;
        skip     <= 1'b1;
        rd_sh    <= res_ok ? res : '0;
        res_ok   <= 1'b0;
        read_end <= 1'b1;
      end else begin
        if (wr_armed && sck_rise) begin
          wr_sh  <= nxt_byte;
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == CNT_W'(CTL_W-1)) begin
            wr_armed <= 1'b0;
            if (to_thr) threshold <= nxt_byte;
            else        chan_addr <= nxt_byte[ADDR_W-1:0];
          end
        end
        if (rd_on && sck_fall) begin
          if (skip) skip  <= 1'b0;
          else      rd_sh <= {rd_sh[RES_W-2:0], 1'b0};
        end
      end
      if (result_load) begin
        res    <= result_in;
        res_ok <= 1'b1;
      end
    end

  assign sdo          = rd_on & rd_sh[RES_W-1];
  assign sdo_en       = rd_on;
  assign data_invalid = !res_ok;

  p_oe_off_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lo |=> !sdo_en);
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    read_end |=> !read_end);
  p_strobe_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    read_end |-> sdo_en);
  p_read_erases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end && !$past(result_load)) |-> data_invalid);
  p_load_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_load |=> !data_invalid);
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rw_hi |=> ($stable(chan_addr) && $stable(threshold)));
endmodule

// File: tb/rw_serial_port_tb.sv
module rw_serial_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [9:0] result_in = '0;
  logic result_load = 1'b0;
  logic sdo, sdo_en, data_invalid, read_end;
  logic [2:0] chan_addr;
  logic [7:0] threshold;
  int checks = 0, fails = 0, strobes = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rw_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .result_in(result_in), .result_load(result_load),
    .chan_addr(chan_addr), .threshold(threshold), .data_invalid(data_invalid),
    .read_end(read_end));

  always @(posedge clk) if (read_end) strobes <= strobes + 1;

  // {is_read, data[9:0], exp_chan[2:0], exp_thr[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 10'h005, 3'd5, 8'd153},
    {1'b0, 10'h008, 3'd5, 8'h08},
    {1'b1, 10'h2A5, 3'd0, 8'h00},
    {1'b0, 10'h003, 3'd3, 8'h08},
    {1'b0, 10'h080, 3'd3, 8'h80},
    {1'b1, 10'h3FF, 3'd0, 8'h00},
    {1'b0, 10'h007, 3'd7, 8'h80},
    {1'b1, 10'h001, 3'd0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (6) @(negedge clk);
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge clk); result_in = v; result_load = 1'b1;
    @(negedge clk); result_load = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input int nclk);
    cs_n = 1'b0; hold();
    rw = 1'b0; hold();
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? b[7-i] : 1'b1;
      sclk = 1'b0; hold();
      sclk = 1'b1; hold();
    end
    cs_n = 1'b1; hold();
    rw = 1'b1; hold();
  endtask

  task automatic read_bits(input int n, output logic [9:0] v, output logic en_seen);
    v = '0;
    cs_n = 1'b0; hold();
    rw = 1'b0; hold();
    rw = 1'b1; hold();
    en_seen = sdo_en;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin sclk = 1'b0; hold(); end
      else begin sclk = 1'b0; hold(); end
      sclk = 1'b1; hold();
      v = {v[8:0], sdo};
    end
  endtask

  task automatic read_end_rw();
    rw = 1'b0; hold();
    cs_n = 1'b1; hold();
    rw = 1'b1; hold();
  endtask

  initial begin
    logic [9:0] got;
    logic en;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold();
    // R1 reset state
    chk("R1 chan", chan_addr, 3'd0);
    chk("R1 thr", threshold, 8'd153);
    chk("R1 oe", sdo_en, 1'b0);
    chk("R1 invalid", data_invalid, 1'b1);

    // table walk: R2/R3 writes, R5/R6 full reads
    foreach (VEC[k]) begin
      if (VEC[k][21]) begin
        load(VEC[k][20:11]);
        read_bits(10, got, en);
        chk("R5 oe on read", en, 1'b1);
        chk("R6 read word", got, VEC[k][20:11]);
        read_end_rw();
      end else begin
        write_byte(VEC[k][18:11], 8);
        chk("R3 chan", chan_addr, VEC[k][10:8]);
        chk("R3 thr", threshold, VEC[k][7:0]);
      end
    end

    // R2/R4 surplus clocks after the byte are ignored
    write_byte(8'h02, 14);
    chk("R2 surplus chan", chan_addr, 3'd2);
    chk("R4 surplus thr", threshold, 8'h80);

    // R10 deselected write and read attempts
    s0 = strobes;
    rw = 1'b0; hold();
    for (int i = 0; i < 8; i++) begin
      sdi = 1'b1; sclk = 1'b0; hold(); sclk = 1'b1; hold();
    end
    rw = 1'b1; hold();
    chk("R10 chan", chan_addr, 3'd2);
    chk("R10 thr", threshold, 8'h80);
    chk("R10 oe", sdo_en, 1'b0);
    chk("R10 strobe", strobes - s0, 0);

    // R6 8-bit read, R9 one strobe, R7 cs rising disables output
    load(10'h3C3);
    chk("R8 valid after load", data_invalid, 1'b0);
    s0 = strobes;
    read_bits(8, got, en);
    chk("R6 8-bit read", got[7:0], 8'hF0);
    chk("R9 strobe count", strobes - s0, 1);
    chk("R8 invalid after read", data_invalid, 1'b1);
    cs_n = 1'b1; hold();
    chk("R7 cs off", sdo_en, 1'b0);
    rw = 1'b0; hold(); rw = 1'b1; hold();

    // R8 repeated read returns zeros; R7 direction fall disables output
    read_bits(10, got, en);
    chk("R8 zeros", got, 10'h000);
    chk("R8 invalid", data_invalid, 1'b1);
    rw = 1'b0; hold();
    chk("R7 rw off", sdo_en, 1'b0);
    cs_n = 1'b1; hold(); rw = 1'b1; hold();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule